// File: doc/BRIEF.md
# Allocation Tag Picker with Dynamic Exclusion

The block hands out a fresh 4-bit memory-colouring tag each time an allocator asks for one. A request carries three pieces of context: the tag that the memory held before, and the tags of the allocations directly to its left and to its right, each with its own valid flag. It also carries a software-programmable set of tags that are permanently forbidden. The block removes all of these from the 16 possible values. It then draws one of the remaining tags with a free-running pseudo-random source. Reused memory never gets its old colour back, and neighbouring allocations never share a colour.

The result appears one cycle after the request, together with a one-cycle valid strobe. Sometimes nothing is left after the exclusions. In that case the block returns the value 0 and raises an error flag, and the allocator decides how to recover. The pseudo-random state runs on every clock and can be reseeded at any time, so a test can replay a tag sequence exactly.

Top module: `alloc_tag_picker`

## Requirements
- R1: After the asynchronous reset, `tag_vld_o` and `tag_err_o` are 0, the static exclude mask is 16'h0001 (tag 0 forbidden), and the random state equals the `SEED` parameter (default 16'hACE1).
- R2: `tag_vld_o` is 1 in exactly the cycle after a clock edge at which `req_i` was 1, and 0 otherwise. `tag_o` and `tag_err_o` are qualified by it.
- R3: A tag whose bit is set in the static exclude mask is never produced without error. A write with `excl_we_i` replaces the whole mask. A request sees the mask value held before its own sampling edge.
- R4: The produced tag never equals the `prev_tag_i` sampled with the request.
- R5: The left and right neighbour tags are excluded only when their valid flags are 1. A neighbour tag whose flag is 0 has no effect on the result.
- R6: Let A be the allowed set, the 16 tags minus the static, previous and valid neighbour tags, and let n = |A|. The output is the k-th lowest member of A, counting from 0, where k = S mod n and S is the random state at the sampling edge.
- R7: When A is empty, the output is tag 0 with `tag_err_o` = 1. Otherwise `tag_err_o` is 0.
- R8: The random state S advances every clock as S' = {S[14:0], S[15]^S[14]^S[12]^S[3]}. When `seed_we_i` is 1, S instead loads `seed_i`, or 16'h0001 if `seed_i` is zero.
- R9: When exactly one tag is allowed, that tag is returned whatever the random state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Tag request strobe |
| prev_tag_i | input | 4 | Tag the memory held before |
| left_vld_i | input | 1 | Left neighbour tag is meaningful |
| left_tag_i | input | 4 | Left neighbour tag |
| right_vld_i | input | 1 | Right neighbour tag is meaningful |
| right_tag_i | input | 4 | Right neighbour tag |
| excl_we_i | input | 1 | Static exclude mask write enable |
| excl_i | input | 16 | New static exclude mask, bit t forbids tag t |
| seed_we_i | input | 1 | Random state load enable |
| seed_i | input | 16 | Random state load value |
| tag_o | output | 4 | Chosen tag |
| tag_vld_o | output | 1 | Result strobe |
| tag_err_o | output | 1 | No tag was available |

## Verification
The bench builds the block with its default parameters: 4-bit tags, a 16-bit random state and seed 16'hACE1. With these settings every allowed-set size from zero to fifteen can be reached. Random static masks, some of them nearly full, and random neighbour validity drive the picker through empty, single-member and wide allowed sets. Reseeding with zero and with random values puts known states into the modulo selection, so each pick is predicted exactly.

// File: rtl/alloc_tag_pkg.sv
package alloc_tag_pkg;
  parameter int TAG_W  = 4;
  parameter int NTAG   = 1 << TAG_W;
  parameter int LFSR_W = 16;
  parameter int CNT_W  = $clog2(NTAG + 1);

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [NTAG-1:0]   mask_t;
  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef struct packed {
    logic vld;
    tag_t tag;
  } nbr_t;

  localparam mask_t RESERVED_RST = mask_t'(1);
  localparam lfsr_t LFSR_ONE     = lfsr_t'(1);

  // x^16 + x^15 + x^13 + x^4 + 1, Fibonacci form
  function automatic lfsr_t lfsr_step(lfsr_t s);
    return {s[LFSR_W-2:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction
endpackage

// File: rtl/tag_lfsr.sv
module tag_lfsr
  import alloc_tag_pkg::*;
#(
  parameter lfsr_t SEED = 16'hACE1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  seed_we_i,
  input  lfsr_t seed_i,
  output lfsr_t state_o
);
  lfsr_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
    end else if (seed_we_i) begin
      state_q <= (seed_i == '0) ? LFSR_ONE : seed_i;
    end else begin
      state_q <= lfsr_step(state_q);
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/tag_excl_build.sv
module tag_excl_build
  import alloc_tag_pkg::*;
(
  input  mask_t static_i,
  input  tag_t  prev_i,
  input  nbr_t  left_i,
  input  nbr_t  right_i,
  output mask_t allowed_o
);
  mask_t dyn;

  always_comb begin
    dyn = '0;
    dyn[prev_i] = 1'b1;
    if (left_i.vld)  dyn[left_i.tag]  = 1'b1;
    if (right_i.vld) dyn[right_i.tag] = 1'b1;
  end

  assign allowed_o = ~(static_i | dyn);
endmodule

// File: rtl/tag_pick.sv
module tag_pick
  import alloc_tag_pkg::*;
(
  input  mask_t allowed_i,
  input  lfsr_t rnd_i,
  output tag_t  tag_o,
  output logic  none_o
);
  cnt_t  cnt;
  cnt_t  k;
  lfsr_t rem;
  cnt_t  pre [NTAG+1];
  mask_t hit;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NTAG; i++) cnt = cnt + cnt_t'(allowed_i[i]);
  end

  assign none_o = (cnt == '0);
  assign rem    = none_o ? '0 : (rnd_i % lfsr_t'(cnt));
  assign k      = cnt_t'(rem);

  assign pre[0] = '0;
  for (genvar g = 0; g < NTAG; g++) begin : g_rank
    assign pre[g+1] = pre[g] + cnt_t'(allowed_i[g]);
    assign hit[g]   = allowed_i[g] && (pre[g] == k);
  end

  always_comb begin
    tag_o = '0;
    for (int i = 0; i < NTAG; i++) begin
      if (hit[i]) tag_o = tag_t'(i);
    end
  end
endmodule

// File: rtl/alloc_tag_picker.sv
module alloc_tag_picker
  import alloc_tag_pkg::*;
#(
  parameter lfsr_t SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [TAG_W-1:0]  prev_tag_i,
  input  logic              left_vld_i,
  input  logic [TAG_W-1:0]  left_tag_i,
  input  logic              right_vld_i,
  input  logic [TAG_W-1:0]  right_tag_i,
  input  logic              excl_we_i,
  input  logic [NTAG-1:0]   excl_i,
  input  logic              seed_we_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic              tag_vld_o,
  output logic              tag_err_o
);
  mask_t excl_q;
  lfsr_t rnd;
  mask_t allowed;
  tag_t  pick;
  logic  none;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        excl_q <= RESERVED_RST;
    else if (excl_we_i) excl_q <= excl_i;
  end

  tag_lfsr #(.SEED(SEED)) u_lfsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .seed_we_i (seed_we_i),
    .seed_i    (seed_i),
    .state_o   (rnd)
  );

  tag_excl_build u_excl (
    .static_i  (excl_q),
    .prev_i    (prev_tag_i),
    .left_i    ('{vld: left_vld_i, tag: left_tag_i}),
    .right_i   ('{vld: right_vld_i, tag: right_tag_i}),
    .allowed_o (allowed)
  );

  tag_pick u_pick (
    .allowed_i (allowed),
    .rnd_i     (rnd),
    .tag_o     (pick),
    .none_o    (none)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_vld_o <= 1'b0;
      tag_err_o <= 1'b0;
      tag_o     <= '0;
    end else begin
      tag_vld_o <= req_i;
      if (req_i) begin
        tag_err_o <= none;
        tag_o     <= none ? '0 : pick;
      end else begin
        tag_err_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alloc_tag_picker_chk.sv
module alloc_tag_picker_chk
  import alloc_tag_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input tag_t        prev_tag_i,
  input logic        left_vld_i,
  input tag_t        left_tag_i,
  input logic        right_vld_i,
  input tag_t        right_tag_i,
  input mask_t       excl_q,
  input tag_t        tag_o,
  input logic        tag_vld_o,
  input logic        tag_err_o
);
  mask_t excl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) excl_d <= RESERVED_RST;
    else         excl_d <= excl_q;
  end

  AST_VLD_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> tag_vld_o); // R2
  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !tag_vld_o); // R2
  AST_STATIC_AVOIDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_vld_o && !tag_err_o) |-> !excl_d[tag_o]); // R3
  AST_PREV_AVOIDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (tag_err_o || tag_o != $past(prev_tag_i))); // R4
  AST_LEFT_AVOIDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && left_vld_i) |=> (tag_err_o || tag_o != $past(left_tag_i))); // R5
  AST_RIGHT_AVOIDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && right_vld_i) |=> (tag_err_o || tag_o != $past(right_tag_i))); // R5
  AST_ERR_TAG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_err_o |-> (tag_vld_o && tag_o == '0)); // R7
endmodule

bind alloc_tag_picker alloc_tag_picker_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .prev_tag_i  (prev_tag_i),
  .left_vld_i  (left_vld_i),
  .left_tag_i  (left_tag_i),
  .right_vld_i (right_vld_i),
  .right_tag_i (right_tag_i),
  .excl_q      (excl_q),
  .tag_o       (tag_o),
  .tag_vld_o   (tag_vld_o),
  .tag_err_o   (tag_err_o)
);

// File: tb/alloc_tag_picker_test.sv
`timescale 1ns/1ps
module alloc_tag_picker_test;
  localparam logic [15:0] SEED_V = 16'hACE1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  prev = '0, lt = '0, rt = '0;
  logic        lv = 1'b0, rv = 1'b0;
  logic        ewe = 1'b0, swe = 1'b0;
  logic [15:0] excl = '0, seed = '0;
  logic [3:0]  tag;
  logic        vld, err;

  int n_run = 0, n_fail = 0;
  logic [15:0] lfsr_m;
  logic [15:0] static_m;

  always #2.5 clk = ~clk;

  alloc_tag_picker uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .prev_tag_i(prev),
    .left_vld_i(lv), .left_tag_i(lt), .right_vld_i(rv), .right_tag_i(rt),
    .excl_we_i(ewe), .excl_i(excl), .seed_we_i(swe), .seed_i(seed),
    .tag_o(tag), .tag_vld_o(vld), .tag_err_o(err)
  );

  // R8 reference state, from the stated recurrence
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lfsr_m <= SEED_V;
    else if (swe) lfsr_m <= (seed == 0) ? 16'h0001 : seed;
    else          lfsr_m <= {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[14] ^ lfsr_m[12] ^ lfsr_m[3]};
  end

  task automatic check(input bit ok, input string r, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic void ref_pick(input logic [15:0] st, input logic [3:0] p,
      input logic l_v, input logic [3:0] l_t, input logic r_v, input logic [3:0] r_t,
      input logic [15:0] s, output logic [3:0] t, output logic e);
    logic [15:0] a;
    int n, k, seen;
    a = ~st;
    a[p] = 1'b0;
    if (l_v) a[l_t] = 1'b0;
    if (r_v) a[r_t] = 1'b0;
    n = $countones(a);
    t = 0; e = (n == 0);
    if (n != 0) begin
      k = int'(s) % n;
      seen = 0;
      for (int i = 0; i < 16; i++) if (a[i]) begin
        if (seen == k) t = 4'(i);
        seen++;
      end
    end
  endfunction

  task automatic do_req(input logic [3:0] p, input logic l_v, input logic [3:0] l_t,
                        input logic r_v, input logic [3:0] r_t, input string r);
    logic [3:0] et; logic ee;
    prev = p; lv = l_v; lt = l_t; rv = r_v; rt = r_t; req = 1'b1;
    ref_pick(static_m, p, l_v, l_t, r_v, r_t, lfsr_m, et, ee);
    @(negedge clk);
    req = 1'b0;
    check(vld == 1'b1, {r, "/R2 vld"}, int'(vld), 1);
    check(err == ee, {r, "/R7 err"}, int'(err), int'(ee));
    check(tag == et, {r, "/R6 tag"}, int'(tag), int'(et));
  endtask

  task automatic set_static(input logic [15:0] m);
    ewe = 1'b1; excl = m;
    @(negedge clk);
    ewe = 1'b0; static_m = m;
  endtask

  task automatic set_seed(input logic [15:0] s);
    swe = 1'b1; seed = s;
    @(negedge clk);
    swe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] t0;
    static_m = 16'h0001;
    void'($urandom(32'd1234));
    #12 rst_n = 1'b1;
    @(negedge clk);
    check(vld == 0, "R1 vld after reset", int'(vld), 0);
    check(err == 0, "R1 err after reset", int'(err), 0);
    // R1: first pick uses reset seed and reset static mask
    do_req(4'd3, 1'b0, 4'd0, 1'b0, 4'd0, "R1 seed/mask");
    @(negedge clk);
    check(vld == 0, "R2 idle no vld", int'(vld), 0);

    // R9 single allowed tag, any state
    set_static(~(16'h0020 | 16'h0200));
    for (int i = 0; i < 4; i++) begin
      do_req(4'd9, 1'b0, 4'd5, 1'b0, 4'd5, "R9 single");
      check(tag == 4'd5, "R9 only tag 5", int'(tag), 5);
    end
    // R5 invalid neighbour ignored; valid neighbour removes it -> R7 empty
    do_req(4'd9, 1'b0, 4'd5, 1'b1, 4'd9, "R5 invalid left ignored");
    check(tag == 4'd5 && !err, "R5 invalid left ignored", int'(tag), 5);
    do_req(4'd9, 1'b1, 4'd5, 1'b0, 4'd0, "R7 left empties set");
    check(err == 1 && tag == 0, "R7 err tag 0", int'(tag), 0);
    do_req(4'd9, 1'b0, 4'd0, 1'b1, 4'd5, "R5 right excluded");
    check(err == 1, "R5 right excluded err", int'(err), 1);
    // R3 full mask
    set_static(16'hFFFF);
    do_req(4'd1, 1'b0, 4'd0, 1'b0, 4'd0, "R3 all static");
    check(err == 1 && tag == 0, "R3 all static err", int'(tag), 0);

    // R8 zero seed loads 1; then known state gives k
    set_static(16'h0000);
    set_seed(16'h0000);
    do_req(4'd0, 1'b0, 4'd0, 1'b0, 4'd0, "R8 zero seed");
    check(tag == 4'd2, "R8 zero seed pick", int'(tag), 2);
    set_seed(16'h000E);
    do_req(4'd15, 1'b0, 4'd0, 1'b0, 4'd0, "R6 k=14 highest");
    check(tag == 4'd14, "R6 k=14", int'(tag), 14);

    // R4 repeated prev avoidance and random mix
    set_static(16'h0001);
    for (int i = 0; i < 600; i++) begin
      int c = $urandom_range(0, 31);
      if (c == 0)      set_static(16'($urandom()) | 16'h0001);
      else if (c == 1) set_static(~(16'h1 << $urandom_range(0, 15)) & ~(16'h1 << $urandom_range(0, 15)));
      else if (c == 2) set_seed(($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom()));
      else if (c == 3) begin
        @(negedge clk);
        check(vld == 0, "R2 idle", int'(vld), 0);
      end else begin
        do_req(4'($urandom()), 1'($urandom()), 4'($urandom()),
               1'($urandom()), 4'($urandom()), "R4 random");
        t0 = prev;
        check(err || tag != t0, "R4 prev avoided", int'(tag), int'(t0));
        check(err || !static_m[tag], "R3 static avoided", int'(tag), 0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule